// File: doc/BRIEF.md
# Chained Vectored Interrupt Controller for Expansion Cards

This block collects eight active-low interrupt request lines from expansion cards and presents them to a 68000-class processor as a single fixed priority level. Each request line is edge-triggered. Software controls it through four 8-bit registers: enable, pending, in-service and mask. When the processor acknowledges the level, the block returns an 8-bit vector number from a fixed window. In-service bits are set at acknowledge and stay set until software clears them.

The processor level is shared with one upstream peripheral through an active-low enable-in / enable-out chain. The block answers an acknowledge only while its enable-in is low. If it has nothing to answer, it drives its enable-out low so that the acknowledge passes on to the next device down the chain.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A falling edge on `irq_ni[k]` sets pending bit k on the following clock edge, but only if enable bit k is set at that edge. Bit k of every register belongs to request line k, and all lines idle high after reset.
- R2: A write that clears enable bit k also clears pending bit k at the same edge. A pending bit can never be set while its enable bit is clear.
- R3: `ipl_o` is 3'd5 whenever any channel is requesting, and 3'd0 otherwise.
- R4: Line k requests when three conditions all hold: its pending bit is set, its mask bit is set, and no in-service bit j with j >= k is set. Among the requesting lines, the highest index wins.
- R5: Line k has channel number 0, 1, 2, 3, 6, 7, 14 or 15, taken in order for k = 0 to 7. During a valid acknowledge, `vec_o` equals 8'h50 plus the winner's channel number. At all other times `vec_o` is 8'h00.
- R6: `vec_valid_o` is high exactly when `iack_i` is high, `iei_ni` is low and some line is requesting.
- R7: In a valid acknowledge cycle, the winning line's pending bit is cleared and its in-service bit is set at the clock edge that ends that cycle.
- R8: A write to the pending or in-service register clears every bit written as 0 and leaves every bit written as 1 unchanged. If an acknowledge or a new edge sets a bit in the same cycle, the set wins.
- R9: Register select `reg_addr_i` chooses the register: 0 is enable, 1 is pending, 2 is in-service, 3 is mask. `reg_rdata_o` shows the selected register combinationally. All four registers are zero after reset.
- R10: `ieo_no` is low exactly when `iei_ni` is low and no line is requesting. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 8 | Card request lines, falling-edge sensitive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register contents |
| iack_i | input | 1 | Processor acknowledge for this level |
| iei_ni | input | 1 | Chain enable-in, active low |
| ieo_no | output | 1 | Chain enable-out, active low |
| ipl_o | output | 3 | Requested processor priority level |
| vec_o | output | 8 | Vector number during acknowledge |
| vec_valid_o | output | 1 | Vector is being driven |

## Verification
The bench builds the block with its default parameters: eight lines, vector high nibble 5 and level 5. At these values every channel number in the gap-filled map can be reached, and the priority masking against in-service bits can be exercised across all eight positions. Directed sequences cover edges on disabled lines, acknowledges with the chain input high and low, nested service, and write-zero clearing. A long randomized phase then mixes edges, register writes and acknowledges in the same cycle, and every cycle is compared against a behavioural model.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_PEND = 2'd1,
    REG_ISR  = 2'd2,
    REG_MASK = 2'd3
  } reg_sel_e;

  // line index to controller channel: 0..3 direct, 4..5 shifted by 2, rest by 8
  function automatic logic [3:0] chan_of(input int unsigned idx);
    int unsigned c;
    if (idx < 4)      c = idx;
    else if (idx < 6) c = idx + 2;
    else              c = idx + 8;
    return c[3:0];
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_ni,
  output logic [N_SRC-1:0] fall_o
);
  logic [N_SRC-1:0] prev_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b1;
      else         prev_q[g] <= irq_ni[g];
    end
    assign fall_o[g] = prev_q[g] & ~irq_ni[g];
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] isr_i,
  output logic             req_o,
  output logic [IDX_W-1:0] win_o,
  output logic [N_SRC-1:0] win_oh_o
);
  logic [N_SRC-1:0] blocked;
  logic [N_SRC-1:0] live;

  // blocked[k]: some in-service bit at k or above
  for (genvar g = 0; g < N_SRC; g++) begin : g_blk
    if (g == N_SRC - 1) begin : g_top
      assign blocked[g] = isr_i[g];
    end else begin : g_mid
      assign blocked[g] = isr_i[g] | blocked[g+1];
    end
  end

  assign live  = pend_i & mask_i & ~blocked;
  assign req_o = |live;

  always_comb begin
    win_o    = '0;
    win_oh_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (live[i]) begin
        win_o    = IDX_W'(i);
        win_oh_o = '0;
        win_oh_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_chain_pkg::*;
#(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] fall_i,
  input  logic             ack_i,
  input  logic [N_SRC-1:0] win_oh_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] isr_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] rdata_o
);
  logic [N_SRC-1:0] en_q, pend_q, isr_q, mask_q;
  logic [N_SRC-1:0] en_d, pend_d, isr_d, mask_d;

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    pend_d = pend_q;
    isr_d  = isr_q;
    if (wr_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_EN:   en_d   = wdata_i;
        REG_MASK: mask_d = wdata_i;
        REG_PEND: pend_d = pend_q & wdata_i;
        REG_ISR:  isr_d  = isr_q & wdata_i;
        default:  ;
      endcase
    end
    if (ack_i) begin
      pend_d = pend_d & ~win_oh_i;
      isr_d  = isr_d | win_oh_i;
    end
    pend_d = (pend_d | (fall_i & en_q)) & en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      isr_q  <= isr_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_EN:   rdata_o = en_q;
      REG_PEND: rdata_o = pend_q;
      REG_ISR:  rdata_o = isr_q;
      REG_MASK: rdata_o = mask_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign isr_o  = isr_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter logic [3:0]  VEC_HI = 4'h5,
  parameter logic [2:0]  IPL    = 3'd5,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_ni,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  input  logic             iack_i,
  input  logic             iei_ni,
  output logic             ieo_no,
  output logic [2:0]       ipl_o,
  output logic [7:0]       vec_o,
  output logic             vec_valid_o
);
  logic [N_SRC-1:0] fall;
  logic [N_SRC-1:0] en_q, pend_q, isr_q, mask_q;
  logic [N_SRC-1:0] win_oh;
  logic [IDX_W-1:0] win;
  logic             req;
  logic             ack;
  logic [3:0]       chan_tbl [N_SRC];

  irq_edge_det #(.N_SRC(N_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_ni (irq_ni),
    .fall_o (fall)
  );

  irq_prio_arb #(.N_SRC(N_SRC)) u_arb (
    .pend_i   (pend_q),
    .mask_i   (mask_q),
    .isr_i    (isr_q),
    .req_o    (req),
    .win_o    (win),
    .win_oh_o (win_oh)
  );

  irq_reg_bank #(.N_SRC(N_SRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .fall_i   (fall),
    .ack_i    (ack),
    .win_oh_i (win_oh),
    .en_o     (en_q),
    .pend_o   (pend_q),
    .isr_o    (isr_q),
    .mask_o   (mask_q),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_chan
    assign chan_tbl[g] = chan_of(g);
  end

  // answer only while upstream grants the chain
  assign ack         = iack_i & ~iei_ni & req;
  assign vec_valid_o = ack;
  assign vec_o       = ack ? {VEC_HI, chan_tbl[win]} : 8'h00;
  assign ipl_o       = req ? IPL : 3'd0;
  assign ieo_no      = iei_ni | req;
endmodule

// File: rtl/irq_chain_ctrl_chk.sv
module irq_chain_ctrl_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter logic [3:0]  VEC_HI = 4'h5,
  parameter logic [2:0]  IPL    = 3'd5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iack_i,
  input logic             iei_ni,
  input logic             ieo_no,
  input logic [2:0]       ipl_o,
  input logic [7:0]       vec_o,
  input logic             vec_valid_o,
  input logic [N_SRC-1:0] isr_i
);
  assert_ipl_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_o == 3'd0) || (ipl_o == IPL));

  assert_vec_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (iack_i && !iei_ni && ipl_o == IPL));

  assert_vec_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o[7:4] == VEC_HI));

  assert_vec_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_o == 8'h00));

  assert_ack_sets_isr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> (isr_i != '0));

  assert_ieo_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ieo_no |-> (!iei_ni && ipl_o == 3'd0 && !vec_valid_o));
endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.N_SRC(N_SRC), .VEC_HI(VEC_HI), .IPL(IPL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iack_i      (iack_i),
  .iei_ni      (iei_ni),
  .ieo_no      (ieo_no),
  .ipl_o       (ipl_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .isr_i       (isr_q)
);

// File: tb/tb_irq_chain_ctrl.sv
`timescale 1ns/100ps
module tb_irq_chain_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_n = 8'hFF;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       iack = 1'b0;
  logic       iei_n = 1'b1;
  logic       ieo_n;
  logic [2:0] ipl;
  logic [7:0] vec;
  logic       vec_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit [7:0] m_en, m_pend, m_isr, m_mask, m_prev;
  int chmap [8] = '{0, 1, 2, 3, 6, 7, 14, 15};

  always #2.5 clk = ~clk;

  irq_chain_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .iack_i(iack), .iei_ni(iei_n), .ieo_no(ieo_n),
    .ipl_o(ipl), .vec_o(vec), .vec_valid_o(vec_valid)
  );

  function automatic int m_winner();
    for (int i = 7; i >= 0; i--) begin
      bit blk = 0;
      for (int j = i; j < 8; j++) if (m_isr[j]) blk = 1;
      if (m_pend[i] && m_mask[i] && !blk) return i;
    end
    return -1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int w = m_winner();
    bit v = iack && !iei_n && (w >= 0);
    int rexp;
    case (addr)
      2'd0: rexp = m_en;
      2'd1: rexp = m_pend;
      2'd2: rexp = m_isr;
      default: rexp = m_mask;
    endcase
    chk({tag, "/R3"}, "ipl", ipl, (w >= 0) ? 5 : 0);
    chk({tag, "/R6"}, "vec_valid", vec_valid, v);
    chk({tag, "/R5"}, "vec", vec, v ? (8'h50 + chmap[w]) : 0);
    chk({tag, "/R10"}, "ieo_n", ieo_n, (iei_n || w >= 0) ? 1 : 0);
    chk({tag, "/R9"}, "rdata", rdata, rexp);
  endtask

  task automatic model_step();
    int w = m_winner();
    bit a = iack && !iei_n && (w >= 0);
    bit [7:0] fall = m_prev & ~irq_n;
    bit [7:0] en_n = m_en;
    m_prev = irq_n;
    if (wr && addr == 2'd0) en_n = wdata;
    if (wr && addr == 2'd3) m_mask = wdata;
    if (wr && addr == 2'd1) m_pend = m_pend & wdata;
    if (wr && addr == 2'd2) m_isr = m_isr & wdata;
    if (a) begin
      m_pend[w] = 1'b0;
      m_isr[w] = 1'b1;
    end
    m_pend = (m_pend | (fall & m_en)) & en_n;
    m_en = en_n;
  endtask

  // one cycle: check outputs for current inputs, clock, advance model
  task automatic cyc(input string tag);
    #1 compare(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d, input string tag);
    wr = 1'b1; addr = a; wdata = d;
    cyc(tag);
    wr = 1'b0;
  endtask

  task automatic pulse(input int k, input string tag);
    irq_n[k] = 1'b0; cyc(tag);
    irq_n[k] = 1'b1; cyc(tag);
  endtask

  task automatic readall(input string tag);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      cyc(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_pend = 0; m_isr = 0; m_mask = 0; m_prev = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R9 and chain pass-through R10
    readall("R9");
    iei_n = 1'b0; cyc("R10"); iei_n = 1'b1;

    // R1: edge on disabled line ignored, pending stays 0
    addr = 2'd1;
    pulse(3, "R1");
    wreg(2'd0, 8'hFF, "R9");
    wreg(2'd3, 8'hFF, "R4");
    addr = 2'd1;
    pulse(2, "R1");
    // level held low produces no second edge
    irq_n[4] = 1'b0; cyc("R1"); cyc("R1"); cyc("R1");
    irq_n[4] = 1'b1; cyc("R1");

    // several pending; ack with chain input high gives no vector (R6)
    pulse(0, "R4"); pulse(5, "R4"); pulse(7, "R4");
    iack = 1'b1; iei_n = 1'b1; cyc("R6");
    // granted ack: line 7 wins, vector 0x5F, R7 moves it to in-service
    iei_n = 1'b0; cyc("R7");
    iack = 1'b0;
    addr = 2'd2; cyc("R7");
    // all others blocked by in-service 7 (R4), so chain passes (R10)
    cyc("R10");
    iei_n = 1'b1;
    // write-one keeps, write-zero clears (R8)
    wreg(2'd2, 8'hFF, "R8");
    addr = 2'd2; cyc("R8");
    wreg(2'd2, 8'h7F, "R8");
    // now line 5 wins, vector 0x57 (R5)
    iack = 1'b1; iei_n = 1'b0; cyc("R5");
    // nested: line 4 lower than in-service 5 is blocked (R4), line 6 not
    iack = 1'b0;
    pulse(4, "R4"); pulse(6, "R4");
    iack = 1'b1; cyc("R5");
    iack = 1'b0; iei_n = 1'b1;
    addr = 2'd1; cyc("R8");
    wreg(2'd1, 8'hEF, "R8");
    // mask off line 2 removes its request (R4)
    wreg(2'd3, 8'h00, "R4");
    wreg(2'd2, 8'h00, "R8");
    addr = 2'd1; cyc("R4");
    // R2: disabling clears pending
    wreg(2'd0, 8'hFB, "R2");
    addr = 2'd1; cyc("R2");
    wreg(2'd0, 8'hFF, "R2");
    wreg(2'd3, 8'hFF, "R4");
    // edge and write-clear same cycle: set wins (R8)
    irq_n[1] = 1'b0; wr = 1'b1; addr = 2'd1; wdata = 8'h00; cyc("R8");
    wr = 1'b0; irq_n[1] = 1'b1; cyc("R8");
    // ack and edge on winner same cycle: pending re-armed (R7)
    iack = 1'b1; iei_n = 1'b0; irq_n[1] = 1'b0; cyc("R7");
    iack = 1'b0; irq_n[1] = 1'b1; cyc("R7");
    readall("R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      irq_n = irq_n ^ (($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
      wr = ($urandom % 6 == 0);
      addr = 2'($urandom);
      wdata = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
      iack = ($urandom % 4 == 0);
      iei_n = ($urandom % 3 == 0);
      cyc("R1R7");
    end
    wr = 1'b0; iack = 1'b0;
    readall("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule